// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Detection

This block is the load half of a load/store unit in an out-of-order core. Loads enter a circular queue in program order, each carrying a sequence number. Each entry also holds the store-queue position that was current when the load entered, or a marker meaning that no store was outstanding. When a load computes its effective address, that address is written into its entry and flagged as valid.

When a store executes, the caller gives the load-queue position that the store recorded at dispatch and the store's address. The block then looks at every load from that position up to the tail. A load that already has an address in the same 256-byte block as the store has read stale data, so it is a violator. The oldest such load is chosen in a single cycle. A load that executes can ask for the same scan of the loads younger than itself. Only the oldest violator seen so far is held. It is announced with a one-cycle pulse and stays visible until the consumer acknowledges it or a squash removes it. Commit retires every leading entry at or below a given sequence number in one cycle. Squash removes every trailing entry above a given sequence number in one cycle.

Top module: `lq_order_top`

## Requirements
- R1: The queue holds at most DEPTH loads. `alloc_ready` is low while DEPTH loads are held, and a request made while it is low changes nothing (`lq_used` keeps its value).
- R2: An allocation writes the slot shown on `alloc_idx`, and `alloc_idx` then steps by one, wrapping modulo DEPTH+1. `head_seq` always shows the sequence number of the oldest held load.
- R3: Each entry keeps the store tag given at allocation, or the no-older-store marker (`alloc_sq_none`=1). The oldest entry's values appear on `head_sq_tag` and `head_sq_none`.
- R4: A commit removes, in one cycle, every entry from the head onward whose sequence number is less than or equal to `cmt_seq`. It stops at the first entry that is larger. If the head entry is already larger, nothing is removed.
- R5: A squash removes, in one cycle, every entry from the tail backward whose sequence number is greater than `squash_seq`, and `alloc_idx` moves back by the same count. In a squash cycle, allocation, commit and checks are ignored.
- R6: A store check covers the slots from `chk_idx` up to, but not including, the tail. A load in that range violates only if its address has been written and bits [ADDR_W-1:8] of its address equal those of `chk_addr`.
- R7: When `chk_from_load`=1, the scan starts one slot after `chk_idx`, so the checking load never matches itself.
- R8: Of several matches, the one closest to the scan start (the oldest) is taken. It replaces the held violator only if no violator is held or its sequence number is strictly smaller. Otherwise the held violator and its outputs are unchanged and no pulse is given.
- R9: When a violator is captured, `viol_pulse` is high for exactly the one cycle after the check. `viol_held` is high while a violator is held, and `viol_idx` and `viol_seq` show it.
- R10: `viol_ack` releases the held violator on the next clock edge. A capture in the same cycle wins and is held.
- R11: A squash with `squash_seq` strictly less than the held violator's sequence number drops the violator. Otherwise the violator stays held.
- R12: After reset the queue is empty (`lq_used`=0, `head_valid`=0, `alloc_ready`=1, `alloc_idx`=0) and no violator is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load this cycle |
| alloc_seq | input | SEQ_W | Sequence number of the new load |
| alloc_sq_none | input | 1 | 1: no store outstanding at allocation |
| alloc_sq_tag | input | SQ_TAG_W | Store-queue tail at allocation |
| alloc_ready | output | 1 | Queue can accept a load |
| alloc_idx | output | IDX_W | Slot the next load will occupy (tail) |
| wb_valid | input | 1 | Address writeback for one entry |
| wb_idx | input | IDX_W | Slot receiving the address |
| wb_addr | input | ADDR_W | Effective address of the load |
| chk_valid | input | 1 | Run an ordering check |
| chk_from_load | input | 1 | 1: the check comes from a load, so skip its own slot |
| chk_idx | input | IDX_W | Start slot recorded by the store, or the load's own slot |
| chk_addr | input | ADDR_W | Address of the checking access |
| cmt_valid | input | 1 | Commit request |
| cmt_seq | input | SEQ_W | Youngest committed sequence number |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Entries above this number are removed |
| viol_pulse | output | 1 | New violator captured (one cycle) |
| viol_idx | output | IDX_W | Slot of the held violator |
| viol_seq | output | SEQ_W | Sequence number of the held violator |
| viol_held | output | 1 | A violator is held |
| viol_ack | input | 1 | Consumer takes the held violator |
| lq_used | output | IDX_W | Number of held loads |
| head_valid | output | 1 | Queue is not empty |
| head_seq | output | SEQ_W | Sequence number of the oldest load |
| head_sq_none | output | 1 | Oldest load's no-older-store marker |
| head_sq_tag | output | SQ_TAG_W | Oldest load's store tag |

## Verification
The assertions assume that sequence numbers grow in allocation order and do not wrap within one test. They also assume that writebacks and checks name occupied slots, and that a store's recorded start slot lies between the head and the tail. The directed tests allocate with rising numbers from 10 upward. They write addresses and start checks only at slots the bench itself has counted as occupied. Each check and squash is issued from a known queue state whose expected slot numbers are worked out in the bench, so the full, wrap and single-cycle bulk-removal cases stay inside those assumptions.

// File: rtl/lq_pkg.sv
package lq_pkg;

  // Ring arithmetic for a queue whose slot count n need not be a power of two.
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    int unsigned s;
    s = a + b;
    return (s >= n) ? s - n : s;
  endfunction

  function automatic int unsigned ring_sub(int unsigned a, int unsigned b, int unsigned n);
    return (a >= b) ? a - b : a + n - b;
  endfunction

  // Steps needed to walk forward from 'from' to 'to'.
  function automatic int unsigned ring_dist(int unsigned from, int unsigned to, int unsigned n);
    return (to >= from) ? to - from : to + n - from;
  endfunction

endpackage

// File: rtl/lq_ptr_ctrl.sv
module lq_ptr_ctrl import lq_pkg::*; #(
  parameter int SLOTS = 7,
  parameter int IDX_W = 3,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alloc_fire,
  input  logic             cmt_valid,
  input  logic [SEQ_W-1:0] cmt_seq,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  input  logic [SEQ_W-1:0] seq_mem [SLOTS],
  output logic [IDX_W-1:0] head,
  output logic [IDX_W-1:0] tail,
  output logic [IDX_W-1:0] used,
  output logic             full,
  output logic [IDX_W-1:0] pop_n,
  output logic [IDX_W-1:0] drop_n
);

  assign used = IDX_W'(ring_dist(32'(head), 32'(tail), SLOTS));
  assign full = IDX_W'(ring_add(32'(tail), 1, SLOTS)) == head;

  // Leading run of committed entries from the head.
  always_comb begin
    logic run;
    logic [IDX_W-1:0] pos;
    pop_n = '0;
    run   = 1'b1;
    for (int k = 0; k < SLOTS - 1; k++) begin
      pos = IDX_W'(ring_add(32'(head), k, SLOTS));
      if (run && k < int'(used) && seq_mem[pos] <= cmt_seq) pop_n = pop_n + IDX_W'(1);
      else run = 1'b0;
    end
  end

  // Trailing run of squashed entries back from the tail.
  always_comb begin
    logic run;
    logic [IDX_W-1:0] pos;
    drop_n = '0;
    run    = 1'b1;
    for (int k = 1; k < SLOTS; k++) begin
      pos = IDX_W'(ring_sub(32'(tail), k, SLOTS));
      if (run && k <= int'(used) && seq_mem[pos] > sq_seq) drop_n = drop_n + IDX_W'(1);
      else run = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head <= '0;
      tail <= '0;
    end else if (sq_valid) begin
      tail <= IDX_W'(ring_sub(32'(tail), 32'(drop_n), SLOTS));
    end else begin
      if (cmt_valid)  head <= IDX_W'(ring_add(32'(head), 32'(pop_n), SLOTS));
      if (alloc_fire) tail <= IDX_W'(ring_add(32'(tail), 1, SLOTS));
    end
  end

  p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    full && !cmt_valid && !sq_valid |=> used == $past(used));

  p_alloc_grows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_fire && !cmt_valid && !sq_valid |=> used == $past(used) + IDX_W'(1));

  p_commit_shrinks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cmt_valid && !sq_valid && !alloc_fire |=> used <= $past(used) && tail == $past(tail));

  p_squash_tail_only_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid |=> used <= $past(used) && head == $past(head));

endmodule

// File: rtl/lq_viol_scan.sv
module lq_viol_scan import lq_pkg::*; #(
  parameter int SLOTS     = 7,
  parameter int IDX_W     = 3,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int BLK_SHIFT = 8
) (
  input  logic [IDX_W-1:0]  head,
  input  logic [IDX_W-1:0]  tail,
  input  logic [IDX_W-1:0]  used,
  input  logic [IDX_W-1:0]  start,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [ADDR_W-1:0] addr_mem [SLOTS],
  input  logic              addr_ok  [SLOTS],
  input  logic [SEQ_W-1:0]  seq_mem  [SLOTS],
  output logic [SLOTS-1:0]  cand_mask,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [SEQ_W-1:0]  hit_seq
);

  logic [IDX_W-1:0] span;

  // Only a start inside [head, tail] opens a window.
  always_comb begin
    if (ring_dist(32'(head), 32'(start), SLOTS) > 32'(used)) span = '0;
    else span = IDX_W'(ring_dist(32'(start), 32'(tail), SLOTS));
  end

  always_comb begin
    logic [IDX_W-1:0] pos;
    logic match;
    cand_mask = '0;
    hit       = 1'b0;
    hit_idx   = '0;
    hit_seq   = '0;
    for (int k = 0; k < SLOTS - 1; k++) begin
      pos   = IDX_W'(ring_add(32'(start), k, SLOTS));
      match = k < int'(span) && addr_ok[pos] &&
              addr_mem[pos][ADDR_W-1:BLK_SHIFT] == chk_addr[ADDR_W-1:BLK_SHIFT];
      if (match) cand_mask[pos] = 1'b1;
      if (match && !hit) begin
        hit     = 1'b1;
        hit_idx = pos;
        hit_seq = seq_mem[pos];
      end
    end
  end

endmodule

// File: rtl/lq_viol_hold.sv
module lq_viol_hold #(
  parameter int IDX_W = 3,
  parameter int SEQ_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             chk_fire,
  input  logic             hit,
  input  logic [IDX_W-1:0] hit_idx,
  input  logic [SEQ_W-1:0] hit_seq,
  input  logic             ack,
  input  logic             sq_valid,
  input  logic [SEQ_W-1:0] sq_seq,
  output logic             held,
  output logic [IDX_W-1:0] held_idx,
  output logic [SEQ_W-1:0] held_seq,
  output logic             pulse
);

  logic take;
  logic sq_kill;

  assign take    = chk_fire && hit && (!held || ack || hit_seq < held_seq);
  assign sq_kill = sq_valid && held && sq_seq < held_seq;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held     <= 1'b0;
      held_idx <= '0;
      held_seq <= '0;
      pulse    <= 1'b0;
    end else begin
      pulse <= take;
      if (take) begin
        held     <= 1'b1;
        held_idx <= hit_idx;
        held_seq <= hit_seq;
      end else if (ack || sq_kill) begin
        held <= 1'b0;
      end
    end
  end

  p_keep_oldest_r8: assert property (@(posedge clk) disable iff (!rst_n)
    held && $past(held) && !$past(ack) |-> held_seq <= $past(held_seq));

  p_pulse_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> held);

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ack && !(chk_fire && hit) |=> !held);

  p_squash_drop_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sq_valid && held && sq_seq < held_seq |=> !held && !pulse);

endmodule

// File: rtl/lq_order_top.sv
module lq_order_top import lq_pkg::*; #(
  parameter int DEPTH     = 6,
  parameter int SEQ_W     = 16,
  parameter int ADDR_W    = 32,
  parameter int SQ_TAG_W  = 4,
  parameter int BLK_SHIFT = 8,
  localparam int SLOTS    = DEPTH + 1,
  localparam int IDX_W    = $clog2(SLOTS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid,
  input  logic [SEQ_W-1:0]    alloc_seq,
  input  logic                alloc_sq_none,
  input  logic [SQ_TAG_W-1:0] alloc_sq_tag,
  output logic                alloc_ready,
  output logic [IDX_W-1:0]    alloc_idx,
  input  logic                wb_valid,
  input  logic [IDX_W-1:0]    wb_idx,
  input  logic [ADDR_W-1:0]   wb_addr,
  input  logic                chk_valid,
  input  logic                chk_from_load,
  input  logic [IDX_W-1:0]    chk_idx,
  input  logic [ADDR_W-1:0]   chk_addr,
  input  logic                cmt_valid,
  input  logic [SEQ_W-1:0]    cmt_seq,
  input  logic                squash_valid,
  input  logic [SEQ_W-1:0]    squash_seq,
  output logic                viol_pulse,
  output logic [IDX_W-1:0]    viol_idx,
  output logic [SEQ_W-1:0]    viol_seq,
  output logic                viol_held,
  input  logic                viol_ack,
  output logic [IDX_W-1:0]    lq_used,
  output logic                head_valid,
  output logic [SEQ_W-1:0]    head_seq,
  output logic                head_sq_none,
  output logic [SQ_TAG_W-1:0] head_sq_tag
);

  logic [SEQ_W-1:0]    seq_mem  [SLOTS];
  logic [ADDR_W-1:0]   addr_mem [SLOTS];
  logic                addr_ok  [SLOTS];
  logic [SQ_TAG_W-1:0] tag_mem  [SLOTS];
  logic                none_mem [SLOTS];

  logic [IDX_W-1:0] head, tail, used, pop_n, drop_n, scan_start, scan_idx;
  logic             full, alloc_fire, chk_fire, scan_hit;
  logic [SEQ_W-1:0] scan_seq;
  logic [SLOTS-1:0] scan_mask;

  assign alloc_ready = !full;
  assign alloc_fire  = alloc_valid && !full && !squash_valid;
  assign chk_fire    = chk_valid && !squash_valid;
  assign scan_start  = chk_from_load ? IDX_W'(ring_add(32'(chk_idx), 1, SLOTS)) : chk_idx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) begin
        seq_mem[i]  <= '0;
        addr_mem[i] <= '0;
        addr_ok[i]  <= 1'b0;
        tag_mem[i]  <= '0;
        none_mem[i] <= 1'b1;
      end
    end else begin
      if (alloc_fire) begin
        seq_mem[tail]  <= alloc_seq;
        addr_ok[tail]  <= 1'b0;
        tag_mem[tail]  <= alloc_sq_tag;
        none_mem[tail] <= alloc_sq_none;
      end
      if (wb_valid && int'(wb_idx) < SLOTS) begin
        addr_mem[wb_idx] <= wb_addr;
        addr_ok[wb_idx]  <= 1'b1;
      end
    end
  end

  lq_ptr_ctrl #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .alloc_fire(alloc_fire),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .sq_valid(squash_valid), .sq_seq(squash_seq), .seq_mem(seq_mem),
    .head(head), .tail(tail), .used(used), .full(full),
    .pop_n(pop_n), .drop_n(drop_n)
  );

  lq_viol_scan #(.SLOTS(SLOTS), .IDX_W(IDX_W), .SEQ_W(SEQ_W),
                 .ADDR_W(ADDR_W), .BLK_SHIFT(BLK_SHIFT)) u_scan (
    .head(head), .tail(tail), .used(used), .start(scan_start), .chk_addr(chk_addr),
    .addr_mem(addr_mem), .addr_ok(addr_ok), .seq_mem(seq_mem),
    .cand_mask(scan_mask), .hit(scan_hit), .hit_idx(scan_idx), .hit_seq(scan_seq)
  );

  lq_viol_hold #(.IDX_W(IDX_W), .SEQ_W(SEQ_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .chk_fire(chk_fire), .hit(scan_hit),
    .hit_idx(scan_idx), .hit_seq(scan_seq), .ack(viol_ack),
    .sq_valid(squash_valid), .sq_seq(squash_seq),
    .held(viol_held), .held_idx(viol_idx), .held_seq(viol_seq), .pulse(viol_pulse)
  );

  assign alloc_idx    = tail;
  assign lq_used      = used;
  assign head_valid   = used != '0;
  assign head_seq     = seq_mem[head];
  assign head_sq_none = none_mem[head];
  assign head_sq_tag  = tag_mem[head];

  p_hit_has_addr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_hit |-> addr_ok[scan_idx] && scan_mask[scan_idx]);

  p_squash_masks_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
    squash_valid |=> !viol_pulse);

  p_no_self_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
    chk_valid && chk_from_load |-> !scan_mask[chk_idx]);

endmodule

// File: tb/lq_order_top_bench.sv
module lq_order_top_bench;

  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic alloc_valid = 0, alloc_sq_none = 0;
  logic [15:0] alloc_seq = '0;
  logic [3:0]  alloc_sq_tag = '0;
  logic alloc_ready;
  logic [IW-1:0] alloc_idx;
  logic wb_valid = 0;
  logic [IW-1:0] wb_idx = '0;
  logic [31:0] wb_addr = '0;
  logic chk_valid = 0, chk_from_load = 0;
  logic [IW-1:0] chk_idx = '0;
  logic [31:0] chk_addr = '0;
  logic cmt_valid = 0;
  logic [15:0] cmt_seq = '0;
  logic squash_valid = 0;
  logic [15:0] squash_seq = '0;
  logic viol_pulse, viol_held;
  logic [IW-1:0] viol_idx;
  logic [15:0] viol_seq;
  logic viol_ack = 0;
  logic [IW-1:0] lq_used;
  logic head_valid, head_sq_none;
  logic [15:0] head_seq;
  logic [3:0] head_sq_tag;

  int n_checks = 0;
  int n_fails  = 0;

  always #10 clk = ~clk;

  lq_order_top u_lq_order_top (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_seq(alloc_seq), .alloc_sq_none(alloc_sq_none),
    .alloc_sq_tag(alloc_sq_tag), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_addr(wb_addr),
    .chk_valid(chk_valid), .chk_from_load(chk_from_load), .chk_idx(chk_idx), .chk_addr(chk_addr),
    .cmt_valid(cmt_valid), .cmt_seq(cmt_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .viol_pulse(viol_pulse), .viol_idx(viol_idx), .viol_seq(viol_seq), .viol_held(viol_held),
    .viol_ack(viol_ack), .lq_used(lq_used), .head_valid(head_valid), .head_seq(head_seq),
    .head_sq_none(head_sq_none), .head_sq_tag(head_sq_tag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One clock edge; sample 1 ns after it.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_alloc(input int seq, input bit none, input int tag);
    alloc_valid = 1; alloc_seq = 16'(seq); alloc_sq_none = none; alloc_sq_tag = 4'(tag);
    step();
    alloc_valid = 0;
  endtask

  task automatic do_wb(input int idx, input int addr);
    wb_valid = 1; wb_idx = IW'(idx); wb_addr = 32'(addr);
    step();
    wb_valid = 0;
  endtask

  task automatic do_chk(input bit from_load, input int idx, input int addr, input bit ack);
    chk_valid = 1; chk_from_load = from_load; chk_idx = IW'(idx); chk_addr = 32'(addr);
    viol_ack = ack;
    step();
    chk_valid = 0; chk_from_load = 0; viol_ack = 0;
  endtask

  task automatic do_cmt(input int seq);
    cmt_valid = 1; cmt_seq = 16'(seq);
    step();
    cmt_valid = 0;
  endtask

  task automatic do_squash(input int seq);
    squash_valid = 1; squash_seq = 16'(seq);
    step();
    squash_valid = 0;
  endtask

  task automatic t_reset();
    check("R12 used", int'(lq_used), 0);
    check("R12 head_valid", int'(head_valid), 0);
    check("R12 alloc_ready", int'(alloc_ready), 1);
    check("R12 alloc_idx", int'(alloc_idx), 0);
    check("R12 viol_held", int'(viol_held), 0);
  endtask

  task automatic t_fill();
    for (int i = 0; i < 6; i++) begin
      check("R2 alloc_idx", int'(alloc_idx), i);
      do_alloc(10 + i, i == 0, i);
    end
    check("R1 used full", int'(lq_used), 6);
    check("R1 not ready", int'(alloc_ready), 0);
    do_alloc(99, 0, 9);
    check("R1 ignored when full", int'(lq_used), 6);
    check("R2 head_seq", int'(head_seq), 10);
    check("R3 head none", int'(head_sq_none), 1);
  endtask

  task automatic t_commit();
    do_cmt(12);
    check("R4 used after bulk commit", int'(lq_used), 3);
    check("R4 head_seq", int'(head_seq), 13);
    check("R3 head tag", int'(head_sq_tag), 3);
    check("R3 head none", int'(head_sq_none), 0);
    do_cmt(5);
    check("R4 commit below head", int'(lq_used), 3);
    check("R2 wrap idx", int'(alloc_idx), 6);
    do_alloc(16, 0, 6);
    check("R2 wrap to 0", int'(alloc_idx), 0);
    do_alloc(17, 0, 7);
    do_alloc(18, 0, 8);
    check("R2 used after wrap", int'(lq_used), 6);
  endtask

  task automatic t_squash();
    do_squash(15);
    check("R5 used", int'(lq_used), 3);
    check("R5 tail back", int'(alloc_idx), 6);
    alloc_valid = 1; alloc_seq = 16'd40;
    do_squash(14);
    alloc_valid = 0;
    check("R5 alloc ignored in squash", int'(lq_used), 2);
    check("R5 tail", int'(alloc_idx), 5);
    do_cmt(14);
    check("R4 empty", int'(head_valid), 0);
  endtask

  task automatic t_violation();
    do_alloc(20, 1, 0);   // slot 5
    do_alloc(21, 0, 1);   // slot 6
    do_alloc(22, 0, 1);   // slot 0
    do_alloc(23, 0, 1);   // slot 1
    do_wb(0, 'h1234);
    do_wb(1, 'h12FF);
    do_chk(0, 6, 'h1300, 0);
    check("R6 other block no pulse", int'(viol_pulse), 0);
    do_chk(0, 6, 'h5000, 0);
    check("R6 unwritten load ignored", int'(viol_pulse), 0);
    do_chk(0, 6, 'h1200, 0);
    check("R9 pulse", int'(viol_pulse), 1);
    check("R8 oldest idx", int'(viol_idx), 0);
    check("R8 oldest seq", int'(viol_seq), 22);
    step();
    check("R9 pulse one cycle", int'(viol_pulse), 0);
    check("R9 held", int'(viol_held), 1);
    do_chk(0, 5, 'h1200, 0);
    check("R8 equal not replaced", int'(viol_pulse), 0);
    check("R8 held seq", int'(viol_seq), 22);
    do_wb(5, 'h7000);
    do_chk(1, 5, 'h7000, 0);
    check("R7 self excluded", int'(viol_pulse), 0);
    do_wb(6, 'h12AA);
    do_chk(1, 5, 'h1280, 0);
    check("R7 load check pulse", int'(viol_pulse), 1);
    check("R8 older replaces idx", int'(viol_idx), 6);
    check("R8 older replaces seq", int'(viol_seq), 21);
  endtask

  task automatic t_squash_violator();
    do_squash(21);
    check("R5 used", int'(lq_used), 2);
    check("R11 kept", int'(viol_held), 1);
    do_squash(20);
    check("R11 dropped", int'(viol_held), 0);
    check("R5 used", int'(lq_used), 1);
  endtask

  task automatic t_ack();
    do_alloc(30, 0, 2);   // slot 6
    do_wb(6, 'h4400);
    do_chk(0, 6, 'h44F0, 0);
    check("R9 pulse", int'(viol_pulse), 1);
    check("R9 seq", int'(viol_seq), 30);
    viol_ack = 1;
    step();
    viol_ack = 0;
    check("R10 ack clears", int'(viol_held), 0);
    do_chk(0, 6, 'h44F0, 1);
    check("R10 capture wins", int'(viol_held), 1);
    check("R10 pulse", int'(viol_pulse), 1);
  endtask

  initial begin
    #(20 * 100000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    step();
    step();
    rst_n = 1;
    step();
    t_reset();
    t_fill();
    t_commit();
    t_squash();
    t_violation();
    t_squash_violator();
    t_ack();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule